// File: doc/BRIEF.md
# I2C Stuck-Bus Timeout Monitor

This block sits beside the open-drain output stage of an I2C target. It watches the sampled SCL and SDA levels and counts slow ticks, one every half second, for as long as either line stays low without a break. A configuration value sets the limit in half-second units. When the count reaches that limit, the block stops the target's own pull-down drivers on both lines and emits a one-cycle timeout event.

A short settle window follows the forced release. At the end of that window the block looks at the bus again. If both lines have gone high, the target itself was the holder. The master now owns the bus, and drive control goes back to the protocol engine. If a line is still low, something outside the target is holding it. The block then raises a sleep request to the power manager and keeps the drivers released until both lines are seen high again.

The block does no protocol decoding. It only gates the drive enables and reports the two conditions.

Top module: `bus_hold_guard`

## Requirements
- R1: With a non-zero limit L, `timeout_pulse` is high in the cycle after the clock edge that samples the L-th tick of one unbroken low period, and is low after each of the earlier ticks.
- R2: When both lines are sampled high, the count of low time goes back to zero. Ticks that arrive while both lines are high add nothing to the count.
- R3: From the edge that raises `timeout_pulse` until the release ends, `scl_pull` and `sda_pull` are both 0, whatever the pull requests are.
- R4: If both lines are high at the last cycle of the settle window (`SETTLE_CYC` cycles after the timeout edge), `sleep_req` stays 0 and the pull requests pass through again from the next cycle.
- R5: If a line is still low at the end of the settle window, `sleep_req` goes to 1 in the cycle after that edge. The drivers stay released.
- R6: `timeout_pulse` is never high in two consecutive cycles.
- R7: While `sleep_req` is 1, the first edge that samples both lines high clears `sleep_req` and ends the forced release.
- R8: A limit of 0 disables the function. Any number of ticks during a low period raises no `timeout_pulse` and does not gate the drivers.
- R9: Outside a forced release, `scl_pull` equals `scl_pull_req` and `sda_pull` equals `sda_pull_req`, where 1 means the line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| scl_pull_req | input | 1 | Protocol engine asks to pull SCL low |
| sda_pull_req | input | 1 | Protocol engine asks to pull SDA low |
| limit_cfg | input | TMO_W | Timeout in half-second units, 0 disables |
| half_sec_tick | input | 1 | One-cycle pulse every half second |
| scl_pull | output | 1 | Gated SCL pull-down enable |
| sda_pull | output | 1 | Gated SDA pull-down enable |
| timeout_pulse | output | 1 | One-cycle timeout event |
| sleep_req | output | 1 | Request for low-power sleep while an outside agent holds the bus |

## Verification
The bench builds the block with a 3-bit limit field and a 2-cycle settle window. With a 3-bit field it can sweep every limit from 1 to 7, both for a hold by the target and for a hold by an outside agent, and it alternates the held line between SCL and SDA. The expected tick number of each timeout is the limit itself. The settle-window decision and the sleep exit are checked at cycle offsets worked out from `SETTLE_CYC`. Separate runs cover a low period broken by a high gap and a disabled limit of 0.

// File: rtl/bhg_pkg.sv
package bhg_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_EXTHOLD = 2'd2
    } guard_st_e;
endpackage

// File: rtl/bhg_low_timer.sv
module bhg_low_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             armed,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             bus_low,
    output logic             hit
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;
    logic [TMO_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        bus_low = !scl_in || !sda_in;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        hit     = armed && (limit != '0) && bus_low && tick
                  && (cnt_inc >= {1'b0, limit});
        if (!armed || !bus_low) begin
            st_d.cnt = '0;
        end else if (tick && (st_q.cnt != '1)) begin
            st_d.cnt = cnt_inc[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && sda_in) |=> (st_q.cnt == '0)); // R2
endmodule

// File: rtl/bhg_release_fsm.sv
module bhg_release_fsm
    import bhg_pkg::*;
#(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic bus_low,
    output logic armed,
    output logic event_o,
    output logic sleep_o
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        guard_st_e        st;
        logic [SET_W-1:0] settle;
        logic             ev;
    } fsm_s;

    fsm_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ev = 1'b0;
        unique case (st_q.st)
            ST_ARMED: begin
                if (hit) begin
                    st_d.st     = ST_SETTLE;
                    st_d.settle = '0;
                    st_d.ev     = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (st_q.settle == SET_LAST) begin
                    st_d.st = bus_low ? ST_EXTHOLD : ST_ARMED;
                end else begin
                    st_d.settle = st_q.settle + 1'b1;
                end
            end
            ST_EXTHOLD: begin
                if (!bus_low) st_d.st = ST_ARMED;
            end
            default: st_d.st = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_ARMED, settle: '0, ev: 1'b0};
        else        st_q <= st_d;
    end

    assign armed   = (st_q.st == ST_ARMED);
    assign event_o = st_q.ev;
    assign sleep_o = (st_q.st == ST_EXTHOLD);

    AST_ONE_CYCLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R6
    AST_SLEEP_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(bus_low)); // R5
    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !bus_low) |=> (!sleep_o && armed)); // R7
endmodule

// File: rtl/bus_hold_guard.sv
module bus_hold_guard #(
    parameter int TMO_W      = 8,
    parameter int SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_pull_req,
    input  logic             sda_pull_req,
    input  logic [TMO_W-1:0] limit_cfg,
    input  logic             half_sec_tick,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic             timeout_pulse,
    output logic             sleep_req
);
    logic armed, bus_low, hit;

    bhg_low_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .armed   (armed),
        .tick    (half_sec_tick),
        .limit   (limit_cfg),
        .bus_low (bus_low),
        .hit     (hit)
    );

    bhg_release_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .bus_low (bus_low),
        .armed   (armed),
        .event_o (timeout_pulse),
        .sleep_o (sleep_req)
    );

    assign scl_pull = scl_pull_req && armed;
    assign sda_pull = sda_pull_req && armed;

    AST_RELEASE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (!scl_pull && !sda_pull)); // R3
    AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> ($past(limit_cfg) != '0)); // R8
    AST_SLEEP_KEEPS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (!scl_pull && !sda_pull)); // R5
endmodule

// File: tb/tb_bus_hold_guard.sv
module tb_bus_hold_guard;
    localparam int TMO_W  = 3;
    localparam int SETTLE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_scl = 1'b0, req_sda = 1'b0;
    logic ext_scl = 1'b0, ext_sda = 1'b0;
    logic tick = 1'b0;
    logic [TMO_W-1:0] limit = '0;
    logic scl_in, sda_in, scl_pull, sda_pull, timeout_pulse, sleep_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_pull || ext_scl);
    assign sda_in = !(sda_pull || ext_sda);

    bus_hold_guard #(.TMO_W(TMO_W), .SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_req(req_scl), .sda_pull_req(req_sda), .limit_cfg(limit),
        .half_sec_tick(tick), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .timeout_pulse(timeout_pulse), .sleep_req(sleep_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick(output logic ev);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        ev = timeout_pulse;
    endtask

    // ticks until the timeout, expected equal to the limit (R1)
    task automatic run_to_timeout(input int lim, output int seen);
        logic ev;
        seen = 0;
        for (int t = 1; t <= lim + 2; t++) begin
            pulse_tick(ev);
            if (ev) begin seen = t; break; end
            idle(2);
        end
    endtask

    initial begin
        int seen;
        logic ev;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(timeout_pulse == 0 && sleep_req == 0, "R9 reset state", int'(timeout_pulse), 0);
        req_scl = 1'b1; idle(1);
        check(scl_pull == 1 && sda_pull == 0, "R9 pass-through", int'(scl_pull), 1);
        req_scl = 1'b0; idle(2);

        // target holds the line: R1, R3, R4, R6
        for (int lim = 1; lim < (1 << TMO_W); lim++) begin
            limit = TMO_W'(lim);
            if (lim % 2 == 0) req_sda = 1'b1; else req_scl = 1'b1;
            idle(1);
            run_to_timeout(lim, seen);
            check(seen == lim, "R1 self-hold tick count", seen, lim);
            check(scl_pull == 0 && sda_pull == 0, "R3 forced release", int'(scl_pull | sda_pull), 0);
            @(negedge clk);
            check(timeout_pulse == 0, "R6 single-cycle event", int'(timeout_pulse), 0);
            check(scl_pull == 0 && sda_pull == 0, "R3 release held in settle", int'(scl_pull | sda_pull), 0);
            idle(SETTLE - 1);
            check(sleep_req == 0, "R4 no sleep after self-hold", int'(sleep_req), 0);
            check((lim % 2 == 0) ? sda_pull == 1 : scl_pull == 1, "R4 control returned", 0, 1);
            req_scl = 1'b0; req_sda = 1'b0;
            idle(3);
        end

        // outside agent holds the line: R1, R5, R7
        for (int lim = 1; lim < (1 << TMO_W); lim++) begin
            limit = TMO_W'(lim);
            req_scl = 1'b1;
            if (lim % 2 == 0) ext_sda = 1'b1; else ext_scl = 1'b1;
            idle(1);
            run_to_timeout(lim, seen);
            check(seen == lim, "R1 external-hold tick count", seen, lim);
            idle(SETTLE - 1);
            check(sleep_req == 0, "R5 sleep not before window end", int'(sleep_req), 0);
            @(negedge clk);
            check(sleep_req == 1, "R5 sleep requested", int'(sleep_req), 1);
            check(scl_pull == 0, "R5 drivers stay released", int'(scl_pull), 0);
            pulse_tick(ev);
            check(ev == 0 && sleep_req == 1, "R5 sleep held while low", int'(sleep_req), 1);
            ext_scl = 1'b0; ext_sda = 1'b0;
            @(negedge clk);
            check(sleep_req == 0, "R7 sleep cleared on high", int'(sleep_req), 0);
            check(scl_pull == 1, "R7 control returned", int'(scl_pull), 1);
            req_scl = 1'b0;
            idle(3);
        end

        // broken low period and ticks while high: R2
        limit = 3'd3;
        ext_sda = 1'b1; idle(1);
        for (int t = 0; t < 2; t++) begin pulse_tick(ev); idle(1); end
        ext_sda = 1'b0; idle(1);
        for (int t = 0; t < 3; t++) begin
            pulse_tick(ev);
            check(ev == 0, "R2 ticks while high ignored", int'(ev), 0);
        end
        ext_scl = 1'b1; idle(1);
        run_to_timeout(3, seen);
        check(seen == 3, "R2 count restarted after high", seen, 3);
        idle(SETTLE + 1);
        ext_scl = 1'b0; idle(3);

        // disabled limit: R8
        limit = '0;
        req_sda = 1'b1; idle(1);
        for (int t = 0; t < 12; t++) begin
            pulse_tick(ev);
            check(ev == 0, "R8 zero limit no event", int'(ev), 0);
        end
        check(sda_pull == 1, "R8 drivers not gated", int'(sda_pull), 1);
        req_sda = 1'b0; idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule